// File: doc/BRIEF.md
# USB Root Port Reset Sequencer

This block manages the reset of a single root port on a USB host controller. It follows a device-present level from the PHY side and records every attach or detach in a connect-change status flag. Software starts a port reset by writing 1 to a reset control bit. From that point the hardware owns the reset. It times the 10 ms reset pulse itself by counting microframe ticks, and it ignores any write of 0 to the bit until the pulse is finished. Software therefore never has to measure the reset length.

The microframe tick comes from a divider on the transceiver clock. The divider counts 7500 cycles with an 8-bit or full-speed serial PHY at 60 MHz, or 3750 cycles with a 16-bit PHY at 30 MHz. A width-select input chooses between the two. When the reset completes, the reset bit clears itself and the port becomes enabled. An enable-change flag is set, and the port speed is reported valid once the external speed-detect logic confirms it. Both change flags are cleared by writing 1 to them, and either flag raises the interrupt request when interrupts are enabled. If the device is removed during a reset, the reset is abandoned and only a connect change is reported.

Top module: `usb_port_reset_seq`

## Requirements
- R1: With `phy_wide_i`=0, `uf_tick_o` pulses for one cycle every `UF_CYC_NARROW` cycles (default 7500).
- R2: With `phy_wide_i`=1, `uf_tick_o` pulses for one cycle every `UF_CYC_WIDE` cycles (default 3750).
- R3: A change of `phy_wide_i` restarts the divider from zero. The first tick after the change comes on the N-th cycle after the change, where N is the period for the new width.
- R4: Any change of `dev_conn_i` shows on `conn_o` and sets `csc_o` one cycle later.
- R5: A write with `wr_rst_val_i`=1, made while the port is connected and no reset is running, raises `port_rst_o` one cycle later and clears `port_en_o`. While the port is disconnected, the same write has no effect.
- R6: The reset ends on the clock edge of the `RST_TICKS`-th tick seen while `port_rst_o` is high (default 80, which is 10 ms). Writes of 0 or 1 to the reset bit during the reset neither shorten nor restart it.
- R7: When a reset completes normally, `port_rst_o` clears and `port_en_o` and `pec_o` set on the same edge. `speed_vld_o` equals `port_en_o` AND `spd_ok_i`.
- R8: Writing 1 on `wr_clr_csc_i` or `wr_clr_pec_i` (with `wr_en_i`) clears that flag on the next edge. A set event on the same edge takes priority over the clear.
- R9: `irq_o` equals `irq_en_i` AND (`csc_o` OR `pec_o`).
- R10: If `dev_conn_i` falls during a reset, the reset is aborted on the next edge. `port_en_o` stays 0, `csc_o` sets, and `pec_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_wide_i | input | 1 | 1 selects the 16-bit PHY divide value, 0 the 8-bit/serial one |
| dev_conn_i | input | 1 | Device-present level from the PHY side |
| spd_ok_i | input | 1 | Speed detection finished (from external logic) |
| wr_en_i | input | 1 | Software write strobe to the port control/status word |
| wr_rst_val_i | input | 1 | Value written to the port-reset bit |
| wr_clr_csc_i | input | 1 | Write-1-to-clear for the connect-change flag |
| wr_clr_pec_i | input | 1 | Write-1-to-clear for the enable-change flag |
| irq_en_i | input | 1 | Port-change interrupt enable |
| uf_tick_o | output | 1 | One-cycle microframe tick |
| conn_o | output | 1 | Registered connection status |
| port_rst_o | output | 1 | Port reset active (read value of the reset bit) |
| port_en_o | output | 1 | Port enabled |
| csc_o | output | 1 | Connect-change flag |
| pec_o | output | 1 | Enable-change flag |
| speed_vld_o | output | 1 | Port speed valid |
| irq_o | output | 1 | Port-change interrupt request |

## Verification
Every registered result (`conn_o`, `csc_o`, `pec_o`, `port_rst_o`, `port_en_o`) appears one edge after the stimulus that causes it. The bench drives inputs on the falling edge and checks at the following falling edge. The tick is combinational from the divider count, so the bench counts falling edges from the width change to the tick: the count must equal the period exactly. The end of a reset is checked every cycle against a count of the ticks observed while the reset is high, with the end expected on the edge of the last counted tick. `irq_o` and `speed_vld_o` are combinational from registered flags and current inputs, so they are compared in the same cycle in which those flags become visible.

// File: rtl/usb_prs_pkg.sv
package usb_prs_pkg;
  typedef enum logic [0:0] {
    PRS_IDLE = 1'b0,
    PRS_BUSY = 1'b1
  } prs_state_e;

  function automatic int unsigned prs_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/uframe_tick_gen.sv
module uframe_tick_gen #(
  parameter int unsigned UF_CYC_NARROW = 7500,
  parameter int unsigned UF_CYC_WIDE   = 3750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phy_wide_i,
  output logic tick_o
);
  import usb_prs_pkg::*;

  localparam int unsigned MAXL = prs_max(UF_CYC_NARROW, UF_CYC_WIDE);
  localparam int unsigned CW   = $clog2(MAXL);
  localparam logic [CW-1:0] LAST_N = CW'(UF_CYC_NARROW - 1);
  localparam logic [CW-1:0] LAST_W = CW'(UF_CYC_WIDE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wide_q;
  logic          sel_chg;
  logic          at_last;

  always_comb begin
    sel_chg = (phy_wide_i != wide_q);
    at_last = (cnt_q == (phy_wide_i ? LAST_W : LAST_N));
    tick_o  = at_last && !sel_chg;
    if (sel_chg || at_last) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wide_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wide_q <= phy_wide_i;
    end
  end
endmodule

// File: rtl/port_rst_fsm.sv
module port_rst_fsm #(
  parameter int unsigned RST_TICKS = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic conn_q_i,
  input  logic dev_conn_i,
  input  logic wr_en_i,
  input  logic wr_rst_val_i,
  output logic busy_o,
  output logic done_o,
  output logic port_en_o
);
  import usb_prs_pkg::*;

  localparam int unsigned TCW = $clog2(RST_TICKS + 1);
  localparam logic [TCW-1:0] TLAST = TCW'(RST_TICKS - 1);

  prs_state_e     st_q, st_d;
  logic [TCW-1:0] tcnt_q, tcnt_d;
  logic           en_q, en_d;
  logic           start;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    en_d   = en_q;
    done_o = 1'b0;
    start  = wr_en_i && wr_rst_val_i && conn_q_i && dev_conn_i;
    unique case (st_q)
      PRS_IDLE: begin
        if (start) begin
          st_d   = PRS_BUSY;
          tcnt_d = '0;
          en_d   = 1'b0;
        end
      end
      PRS_BUSY: begin
        if (!dev_conn_i) begin
          st_d = PRS_IDLE;
        end else if (tick_i) begin
          if (tcnt_q == TLAST) begin
            st_d   = PRS_IDLE;
            en_d   = 1'b1;
            done_o = 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      default: st_d = PRS_IDLE;
    endcase
    if (!dev_conn_i) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PRS_IDLE;
      tcnt_q <= '0;
      en_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      en_q   <= en_d;
    end
  end

  assign busy_o    = (st_q == PRS_BUSY);
  assign port_en_o = en_q;
endmodule

// File: rtl/port_chg_status.sv
module port_chg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_conn_i,
  input  logic done_i,
  input  logic wr_en_i,
  input  logic wr_clr_csc_i,
  input  logic wr_clr_pec_i,
  input  logic irq_en_i,
  output logic conn_o,
  output logic csc_o,
  output logic pec_o,
  output logic irq_o
);
  logic conn_q, csc_q, pec_q;
  logic csc_d, pec_d;

  always_comb begin
    csc_d = csc_q;
    pec_d = pec_q;
    if (wr_en_i && wr_clr_csc_i) csc_d = 1'b0;
    if (wr_en_i && wr_clr_pec_i) pec_d = 1'b0;
    if (dev_conn_i != conn_q)    csc_d = 1'b1;
    if (done_i)                  pec_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      csc_q  <= 1'b0;
      pec_q  <= 1'b0;
    end else begin
      conn_q <= dev_conn_i;
      csc_q  <= csc_d;
      pec_q  <= pec_d;
    end
  end

  assign conn_o = conn_q;
  assign csc_o  = csc_q;
  assign pec_o  = pec_q;
  assign irq_o  = irq_en_i && (csc_q || pec_q);
endmodule

// File: rtl/usb_port_reset_seq.sv
module usb_port_reset_seq #(
  parameter int unsigned UF_CYC_NARROW = 7500,
  parameter int unsigned UF_CYC_WIDE   = 3750,
  parameter int unsigned RST_TICKS     = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phy_wide_i,
  input  logic dev_conn_i,
  input  logic spd_ok_i,
  input  logic wr_en_i,
  input  logic wr_rst_val_i,
  input  logic wr_clr_csc_i,
  input  logic wr_clr_pec_i,
  input  logic irq_en_i,
  output logic uf_tick_o,
  output logic conn_o,
  output logic port_rst_o,
  output logic port_en_o,
  output logic csc_o,
  output logic pec_o,
  output logic speed_vld_o,
  output logic irq_o
);
  logic tick;
  logic done;
  logic conn_q;

  uframe_tick_gen #(
    .UF_CYC_NARROW (UF_CYC_NARROW),
    .UF_CYC_WIDE   (UF_CYC_WIDE)
  ) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .phy_wide_i (phy_wide_i),
    .tick_o     (tick)
  );

  port_rst_fsm #(
    .RST_TICKS (RST_TICKS)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .conn_q_i     (conn_q),
    .dev_conn_i   (dev_conn_i),
    .wr_en_i      (wr_en_i),
    .wr_rst_val_i (wr_rst_val_i),
    .busy_o       (port_rst_o),
    .done_o       (done),
    .port_en_o    (port_en_o)
  );

  port_chg_status u_sts (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_conn_i   (dev_conn_i),
    .done_i       (done),
    .wr_en_i      (wr_en_i),
    .wr_clr_csc_i (wr_clr_csc_i),
    .wr_clr_pec_i (wr_clr_pec_i),
    .irq_en_i     (irq_en_i),
    .conn_o       (conn_q),
    .csc_o        (csc_o),
    .pec_o        (pec_o),
    .irq_o        (irq_o)
  );

  assign uf_tick_o   = tick;
  assign conn_o      = conn_q;
  assign speed_vld_o = port_en_o && spd_ok_i;
endmodule

// File: rtl/usb_port_reset_seq_chk.sv
module usb_port_reset_seq_chk #(
  parameter int unsigned UF_CYC_NARROW = 7500,
  parameter int unsigned UF_CYC_WIDE   = 3750
) (
  input logic clk,
  input logic rst_n,
  input logic phy_wide_i,
  input logic dev_conn_i,
  input logic uf_tick_o,
  input logic conn_o,
  input logic port_rst_o,
  input logic port_en_o,
  input logic csc_o,
  input logic pec_o
);
  localparam int unsigned GW = $clog2((UF_CYC_NARROW > UF_CYC_WIDE ? UF_CYC_NARROW : UF_CYC_WIDE) + 2);

  logic [GW-1:0] gap_q;
  logic          wsel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      wsel_q <= 1'b0;
    end else begin
      wsel_q <= phy_wide_i;
      if (uf_tick_o || (phy_wide_i != wsel_q)) gap_q <= '0;
      else                                      gap_q <= gap_q + 1'b1;
    end
  end

  // R1 / R2: the tick never comes later than one period
  assert_tick_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_wide_i == wsel_q) |-> (gap_q < GW'(phy_wide_i ? UF_CYC_WIDE : UF_CYC_NARROW)));

  assert_conn_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_conn_i != conn_o) |=> csc_o);

  assert_rst_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst_o |-> !port_en_o);

  assert_rst_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rst_o && dev_conn_i && !uf_tick_o) |=> port_rst_o);

  assert_rst_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(port_rst_o) && conn_o) |-> (port_en_o && pec_o));

  assert_rst_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(port_rst_o) && !conn_o) |-> (!port_en_o && csc_o && !$rose(pec_o)));
endmodule

bind usb_port_reset_seq usb_port_reset_seq_chk #(
  .UF_CYC_NARROW (UF_CYC_NARROW),
  .UF_CYC_WIDE   (UF_CYC_WIDE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phy_wide_i (phy_wide_i),
  .dev_conn_i (dev_conn_i),
  .uf_tick_o  (uf_tick_o),
  .conn_o     (conn_o),
  .port_rst_o (port_rst_o),
  .port_en_o  (port_en_o),
  .csc_o      (csc_o),
  .pec_o      (pec_o)
);

// File: tb/usb_port_reset_seq_tb.sv
module usb_port_reset_seq_tb;
  localparam int unsigned NARROW = 20;
  localparam int unsigned WIDE   = 10;
  localparam int unsigned TICKS  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phy_wide_i = 1'b0, dev_conn_i = 1'b0, spd_ok_i = 1'b0;
  logic wr_en_i = 1'b0, wr_rst_val_i = 1'b0, wr_clr_csc_i = 1'b0, wr_clr_pec_i = 1'b0;
  logic irq_en_i = 1'b0;
  logic uf_tick_o, conn_o, port_rst_o, port_en_o, csc_o, pec_o, speed_vld_o, irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usb_port_reset_seq #(
    .UF_CYC_NARROW (NARROW),
    .UF_CYC_WIDE   (WIDE),
    .RST_TICKS     (TICKS)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .phy_wide_i (phy_wide_i), .dev_conn_i (dev_conn_i),
    .spd_ok_i (spd_ok_i), .wr_en_i (wr_en_i), .wr_rst_val_i (wr_rst_val_i),
    .wr_clr_csc_i (wr_clr_csc_i), .wr_clr_pec_i (wr_clr_pec_i), .irq_en_i (irq_en_i),
    .uf_tick_o (uf_tick_o), .conn_o (conn_o), .port_rst_o (port_rst_o),
    .port_en_o (port_en_o), .csc_o (csc_o), .pec_o (pec_o),
    .speed_vld_o (speed_vld_o), .irq_o (irq_o)
  );

  function automatic logic exp_irq(input logic en, input logic c, input logic p);
    return en & (c | p);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges_to_tick(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      n++;
      if (uf_tick_o) break;
    end
  endtask

  task automatic run_reset(output int ticks_seen);
    int n;
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (port_rst_o != (n < int'(TICKS))) begin
        chk("R6 reset level", port_rst_o, (n < int'(TICKS)) ? 1 : 0);
        break;
      end
      if (!port_rst_o) break;
      chk("R5 enable low in reset", port_en_o, 0);
      if (uf_tick_o) n++;
      wr_en_i      = $urandom_range(0, 1);
      wr_rst_val_i = $urandom_range(0, 1);
    end
    wr_en_i = 1'b0;
    wr_rst_val_i = 1'b0;
    ticks_seen = n;
  endtask

  initial begin
    int n;
    logic ec, ep;
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    chk("reset state rst", port_rst_o, 0);
    chk("reset state en", port_en_o, 0);
    chk("reset state flags", {csc_o, pec_o, irq_o}, 0);
    rst_n = 1'b1;

    // R1: narrow period
    edges_to_tick(n);
    edges_to_tick(n);
    chk("R1 narrow period", n, NARROW);

    // R3 + R2: restart on width change
    phy_wide_i = 1'b1;
    edges_to_tick(n);
    chk("R3 first tick after width change", n, WIDE);
    edges_to_tick(n);
    chk("R2 wide period", n, WIDE);
    phy_wide_i = 1'b0;
    edges_to_tick(n);
    chk("R3 back to narrow", n, NARROW);

    // R5: reset write while disconnected ignored
    wr_en_i = 1'b1; wr_rst_val_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wr_rst_val_i = 1'b0;
    chk("R5 no reset while disconnected", port_rst_o, 0);

    // R4: attach
    dev_conn_i = 1'b1;
    irq_en_i = 1'b1;
    @(negedge clk);
    chk("R4 conn", conn_o, 1);
    chk("R4 csc", csc_o, 1);
    chk("R9 irq on csc", irq_o, 1);
    wr_en_i = 1'b1; wr_clr_csc_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wr_clr_csc_i = 1'b0;
    chk("R8 csc cleared", csc_o, 0);
    chk("R9 irq idle", irq_o, 0);

    // R5/R6/R7: full reset with random writes
    spd_ok_i = 1'b1;
    wr_en_i = 1'b1; wr_rst_val_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wr_rst_val_i = 1'b0;
    chk("R5 reset started", port_rst_o, 1);
    run_reset(n);
    chk("R6 ticks counted", n, TICKS);
    chk("R7 enabled", port_en_o, 1);
    chk("R7 pec", pec_o, 1);
    chk("R7 speed valid", speed_vld_o, 1);
    spd_ok_i = 1'b0;
    #0;
    chk("R7 speed waits for detect", speed_vld_o, 0);
    chk("R9 irq on pec", irq_o, 1);

    // R10: abort, with same-cycle csc clear (R8 priority)
    wr_en_i = 1'b1; wr_clr_pec_i = 1'b1;
    @(negedge clk);
    wr_clr_pec_i = 1'b0;
    wr_rst_val_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wr_rst_val_i = 1'b0;
    chk("R5 second reset", port_rst_o, 1);
    chk("R5 enable dropped", port_en_o, 0);
    n = 0;
    while (n < 2) begin
      @(negedge clk);
      if (uf_tick_o) n++;
    end
    dev_conn_i = 1'b0;
    wr_en_i = 1'b1; wr_clr_csc_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wr_clr_csc_i = 1'b0;
    chk("R10 reset aborted", port_rst_o, 0);
    chk("R10 not enabled", port_en_o, 0);
    chk("R10 csc set, R8 set wins", csc_o, 1);
    chk("R10 no pec", pec_o, 0);

    // R8/R9: random flag clears and interrupt enable
    dev_conn_i = 1'b1;
    @(negedge clk);
    ec = 1'b1; ep = 1'b0;
    for (int k = 0; k < 300; k++) begin
      logic c_csc, c_pec, we;
      if (k % 50 == 0) begin
        dev_conn_i = ~dev_conn_i;
        @(negedge clk);
        ec = 1'b1;
      end
      we = $urandom_range(0, 1);
      c_csc = ($urandom_range(0, 3) == 0);
      c_pec = ($urandom_range(0, 3) == 0);
      irq_en_i = $urandom_range(0, 1);
      wr_en_i = we; wr_clr_csc_i = c_csc; wr_clr_pec_i = c_pec;
      wr_rst_val_i = 1'b0;
      if (we && c_csc) ec = 1'b0;
      if (we && c_pec) ep = 1'b0;
      @(negedge clk);
      wr_en_i = 1'b0; wr_clr_csc_i = 1'b0; wr_clr_pec_i = 1'b0;
      chk("R8 csc model", csc_o, ec);
      chk("R8 pec model", pec_o, ep);
      chk("R9 irq model", irq_o, exp_irq(irq_en_i, ec, ep));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule